// File: doc/BRIEF.md
# TDM Time-Slot Channel with Programmable Slots

This block is one channel of a serial time-division-multiplexed port. A bit clock and a frame-sync pulse set up a position counter that runs through eight bit periods per slot and a fixed number of slots per frame. While the position counter is in the programmed receive slot, the channel shifts an 8-bit word in from the serial data input. It sends a word out in the programmed transmit slot. The two slots are set independently. In every other slot the output enable is low, so other channels can share the line.

A mode input selects what happens to a captured word:

- **Active:** the word is offered on a valid/ready stream to an external processing engine, and the engine's answer becomes the next transmitted word.
- **Bypass:** the captured word is transmitted unchanged.
- **Idle:** the channel neither forwards samples nor drives the line.
- **Mute:** processing keeps running but the line is not driven.

A strap input forces both slots to slot 0. A configuration-busy input puts the output into high impedance while a host rewrites the channel settings.

The bit clock, the frame sync and the serial data are sampled into the system clock domain through a short synchronizer. Input bits are taken on the rising bit-clock edge. Output bits change on the falling edge.

The outgoing processing stream follows these rules:

- It holds its word and its valid flag until it sees ready.
- If a new capture completes while the previous word is still waiting, the newer word replaces it. The serial frame cannot be stalled, so the stream does not back-pressure the line.
- The result stream is always ready. A result beat is stored only in Active or Mute.

Top module: `tdm_slot_channel`

## Requirements
- R1: After reset the output enable is 0, the processing stream valid is 0, the result ready is 1, and the transmit word is 0.
- R2: A rising bit-clock edge seen with frame sync high is bit 0 of slot 0. Each later rising edge advances the bit index 0..7, then the slot index 0..SLOTS-1. After the last bit of slot SLOTS-1 the count wraps to bit 0 of slot 0 without a frame sync.
- R3: The 8 bits taken on rising edges within the receive slot form one sample. The first bit taken is the MSB (bit 7). The sample is complete at bit index 7.
- R4: In Active or Mute, each completed sample raises the processing stream valid with the sample as data. Valid and data hold until ready, except that a newer sample replaces a waiting one. A result beat (result valid high, ready always 1) becomes the transmit word.
- R5: On the falling edge after the rising edge of bit b of the transmit slot, the output carries bit 7-b of the transmit word and the enable is 1 (when not gated by R7-R9). The word is taken at bit 0. The enable is 0 after falling edges in any other slot.
- R6: In Bypass, each completed sample becomes the transmit word directly. This also holds when the receive slot equals the transmit slot; that word is sent in the following frame.
- R7: In Idle (mode 2) the enable is 0 and the processing stream valid is cleared. The transmit word keeps its value.
- R8: In Mute (mode 3) the enable is 0 while processing and result capture continue as in Active.
- R9: While the configuration-busy input is 1, the enable is 0 in the same cycle.
- R10: With the strap input high, both the receive slot and the transmit slot are 0, whatever the slot inputs hold.
- R11: Before any sample or result has been stored, the transmit slot carries 8'h00.

Mode encoding: 0 Active, 1 Bypass, 2 Idle, 3 Mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync, sampled on the rising bit-clock edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |
| mode_i | input | 2 | Channel mode (0 Active, 1 Bypass, 2 Idle, 3 Mute) |
| in_slot_i | input | $clog2(SLOTS) | Receive slot number |
| out_slot_i | input | $clog2(SLOTS) | Transmit slot number |
| hw_mode_i | input | 1 | Strap: forces both slots to 0 |
| cfg_busy_i | input | 1 | Configuration update in progress; forces high impedance |
| proc_tdata_o | output | SAMPLE_W | Captured sample to the processing engine |
| proc_tvalid_o | output | 1 | Sample valid |
| proc_tready_i | input | 1 | Engine ready |
| res_tdata_i | input | SAMPLE_W | Processed result |
| res_tvalid_i | input | 1 | Result valid |
| res_tready_o | output | 1 | Result ready, always 1 |

## Verification
On every cycle, the assertions check that:

- the position counter restarts on frame sync and steps one bit per rising edge;
- a waiting sample keeps its valid flag and data under back-pressure unless it is replaced;
- Idle clears the stream;
- Mute and configuration-busy keep the line undriven;
- the serial output changes only after a falling edge.

Only the bench scenarios can show that the right bits land in the right slot with MSB first. They also show:

- the one-frame delay when the receive and transmit slots coincide;
- that Mute keeps updating the transmit word and Idle leaves it untouched;
- that the strap overrides the slot inputs;
- that a stalled engine ends up with the newest sample.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  typedef enum logic [1:0] {
    CH_ACTIVE = 2'd0,
    CH_BYPASS = 2'd1,
    CH_IDLE   = 2'd2,
    CH_MUTE   = 2'd3
  } ch_mode_e;

  // Modes in which captured samples go to the processing engine.
  function automatic logic mode_processes(input ch_mode_e m);
    return (m == CH_ACTIVE) || (m == CH_MUTE);
  endfunction

  // Modes in which the serial line may be driven.
  function automatic logic mode_drives(input ch_mode_e m);
    return (m == CH_ACTIVE) || (m == CH_BYPASS);
  endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdi_i,
  output logic rise_p,
  output logic fall_p,
  output logic fsync_s,
  output logic sdi_s
);

  logic [STAGES-1:0][2:0] stg;
  logic                   bclk_q;
  logic [2:0]             last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {bclk_i, fsync_i, sdi_i};
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], {bclk_i, fsync_i, sdi_i}};
      end
    end
  endgenerate

  assign last = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= last[2];
  end

  assign rise_p  = last[2] & ~bclk_q;
  assign fall_p  = ~last[2] & bclk_q;
  assign fsync_s = last[1];
  assign sdi_s   = last[0];

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
  parameter int SLOTS    = 32,
  parameter int SAMPLE_W = 8,
  localparam int SW      = $clog2(SLOTS),
  localparam int BW      = $clog2(SAMPLE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_p,
  input  logic          fsync_s,
  input  logic          sdi_s,
  output logic [BW-1:0] cur_bit,
  output logic [SW-1:0] cur_slot,
  output logic          bit_stb,
  output logic          bit_dat
);

  localparam logic [BW-1:0] LAST_BIT  = BW'(SAMPLE_W - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      // Start on the final position so the first edge lands on bit 0 of slot 0.
      cur_bit  <= LAST_BIT;
      cur_slot <= LAST_SLOT;
      bit_stb  <= 1'b0;
      bit_dat  <= 1'b0;
    end else begin
      bit_stb <= rise_p;
      if (rise_p) begin
        bit_dat <= sdi_s;
        if (fsync_s) begin
          cur_bit  <= '0;
          cur_slot <= '0;
        end else if (cur_bit == LAST_BIT) begin
          cur_bit  <= '0;
          cur_slot <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
        end else begin
          cur_bit <= cur_bit + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int SLOTS    = 32,
  parameter int SAMPLE_W = 8,
  localparam int SW      = $clog2(SLOTS),
  localparam int BW      = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                bit_dat,
  input  logic [BW-1:0]       cur_bit,
  input  logic [SW-1:0]       cur_slot,
  input  logic [SW-1:0]       rx_slot,
  output logic                cap_stb,
  output logic [SAMPLE_W-1:0] cap_data
);

  localparam logic [BW-1:0] LAST_BIT = BW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] shreg_nxt;

  assign shreg_nxt = {shreg[SAMPLE_W-2:0], bit_dat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cap_stb  <= 1'b0;
      cap_data <= '0;
    end else begin
      cap_stb <= 1'b0;
      if (bit_stb && (cur_slot == rx_slot)) begin
        shreg <= shreg_nxt;
        if (cur_bit == LAST_BIT) begin
          cap_data <= shreg_nxt;
          cap_stb  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_sample_path.sv
module tdm_sample_path
  import tdm_slot_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ch_mode_e            mode,
  input  logic                cap_stb,
  input  logic [SAMPLE_W-1:0] cap_data,
  output logic [SAMPLE_W-1:0] proc_tdata,
  output logic                proc_tvalid,
  input  logic                proc_tready,
  input  logic [SAMPLE_W-1:0] res_tdata,
  input  logic                res_tvalid,
  output logic                res_tready,
  output logic [SAMPLE_W-1:0] tx_word
);

  logic processing;

  assign processing = mode_processes(mode);
  assign res_tready = 1'b1;

  // Outgoing stream: a newer capture replaces a waiting one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proc_tvalid <= 1'b0;
      proc_tdata  <= '0;
    end else if (!processing) begin
      proc_tvalid <= 1'b0;
    end else if (cap_stb) begin
      proc_tvalid <= 1'b1;
      proc_tdata  <= cap_data;
    end else if (proc_tready) begin
      proc_tvalid <= 1'b0;
    end
  end

  // Word that the next transmit slot will send.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word <= '0;
    end else if (mode == CH_BYPASS) begin
      if (cap_stb) tx_word <= cap_data;
    end else if (processing && res_tvalid) begin
      tx_word <= res_tdata;
    end
  end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int SLOTS    = 32,
  parameter int SAMPLE_W = 8,
  localparam int SW      = $clog2(SLOTS),
  localparam int BW      = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_p,
  input  logic [BW-1:0]       cur_bit,
  input  logic [SW-1:0]       cur_slot,
  input  logic [SW-1:0]       tx_slot,
  input  logic [SAMPLE_W-1:0] tx_word,
  output logic                sdo,
  output logic                slot_oe
);

  localparam logic [BW-1:0] MSB_IDX = BW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      sdo     <= 1'b0;
      slot_oe <= 1'b0;
    end else if (fall_p) begin
      if (cur_slot == tx_slot) begin
        slot_oe <= 1'b1;
        if (cur_bit == '0) begin
          shreg <= tx_word;
          sdo   <= tx_word[SAMPLE_W-1];
        end else begin
          sdo <= shreg[MSB_IDX - cur_bit];
        end
      end else begin
        slot_oe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tdm_slot_channel.sv
module tdm_slot_channel
  import tdm_slot_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int SAMPLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bclk_i,
  input  logic                      fsync_i,
  input  logic                      sdi_i,
  output logic                      sdo_o,
  output logic                      sdo_oe_o,
  input  logic [1:0]                mode_i,
  input  logic [$clog2(SLOTS)-1:0]  in_slot_i,
  input  logic [$clog2(SLOTS)-1:0]  out_slot_i,
  input  logic                      hw_mode_i,
  input  logic                      cfg_busy_i,
  output logic [SAMPLE_W-1:0]       proc_tdata_o,
  output logic                      proc_tvalid_o,
  input  logic                      proc_tready_i,
  input  logic [SAMPLE_W-1:0]       res_tdata_i,
  input  logic                      res_tvalid_i,
  output logic                      res_tready_o
);

  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(SAMPLE_W);

  ch_mode_e            mode;
  logic                rise_p, fall_p, fsync_s, sdi_s;
  logic [BW-1:0]       cur_bit;
  logic [SW-1:0]       cur_slot;
  logic                bit_stb, bit_dat;
  logic [SW-1:0]       rx_slot, tx_slot;
  logic                cap_stb;
  logic [SAMPLE_W-1:0] cap_data;
  logic [SAMPLE_W-1:0] tx_word;
  logic                slot_oe;

  assign mode    = ch_mode_e'(mode_i);
  assign rx_slot = hw_mode_i ? '0 : in_slot_i;
  assign tx_slot = hw_mode_i ? '0 : out_slot_i;

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i), .sdi_i(sdi_i),
    .rise_p(rise_p), .fall_p(fall_p), .fsync_s(fsync_s), .sdi_s(sdi_s)
  );

  tdm_frame_counter #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise_p(rise_p), .fsync_s(fsync_s), .sdi_s(sdi_s),
    .cur_bit(cur_bit), .cur_slot(cur_slot), .bit_stb(bit_stb), .bit_dat(bit_dat)
  );

  tdm_rx_capture #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_dat(bit_dat),
    .cur_bit(cur_bit), .cur_slot(cur_slot), .rx_slot(rx_slot),
    .cap_stb(cap_stb), .cap_data(cap_data)
  );

  tdm_sample_path #(.SAMPLE_W(SAMPLE_W)) u_path (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cap_stb(cap_stb), .cap_data(cap_data),
    .proc_tdata(proc_tdata_o), .proc_tvalid(proc_tvalid_o), .proc_tready(proc_tready_i),
    .res_tdata(res_tdata_i), .res_tvalid(res_tvalid_i), .res_tready(res_tready_o),
    .tx_word(tx_word)
  );

  tdm_tx_serializer #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_p(fall_p), .cur_bit(cur_bit), .cur_slot(cur_slot),
    .tx_slot(tx_slot), .tx_word(tx_word), .sdo(sdo_o), .slot_oe(slot_oe)
  );

  assign sdo_oe_o = slot_oe & mode_drives(mode) & ~cfg_busy_i;

endmodule

// File: rtl/tdm_slot_channel_chk.sv
module tdm_slot_channel_chk
  import tdm_slot_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int SAMPLE_W = 8,
  localparam int SW      = $clog2(SLOTS),
  localparam int BW      = $clog2(SAMPLE_W)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rise_p,
  input logic                fall_p,
  input logic                fsync_s,
  input logic [BW-1:0]       cur_bit,
  input logic [SW-1:0]       cur_slot,
  input logic                cap_stb,
  input logic [1:0]          mode_i,
  input logic                cfg_busy_i,
  input logic                sdo_o,
  input logic                sdo_oe_o,
  input logic [SAMPLE_W-1:0] proc_tdata_o,
  input logic                proc_tvalid_o,
  input logic                proc_tready_i
);

  localparam logic [BW-1:0] LAST_BIT = BW'(SAMPLE_W - 1);

  logic proc_mode;
  assign proc_mode = (mode_i == CH_ACTIVE) || (mode_i == CH_MUTE);

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p && fsync_s) |=> (cur_bit == '0 && cur_slot == '0));

  assert_bit_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p && !fsync_s && cur_bit != LAST_BIT) |=> (cur_bit == $past(cur_bit) + 1'b1));

  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_tvalid_o && !proc_tready_i && proc_mode) |=> proc_tvalid_o);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_tvalid_o && !proc_tready_i && proc_mode && !cap_stb) |=> $stable(proc_tdata_o));

  assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(fall_p));

  assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CH_IDLE) |=> !proc_tvalid_o);

  assert_mute_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CH_MUTE || mode_i == CH_IDLE) |-> !sdo_oe_o);

  assert_busy_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy_i |-> !sdo_oe_o);

endmodule

bind tdm_slot_channel tdm_slot_channel_chk #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_p(rise_p), .fall_p(fall_p), .fsync_s(fsync_s),
  .cur_bit(cur_bit), .cur_slot(cur_slot), .cap_stb(cap_stb), .mode_i(mode_i),
  .cfg_busy_i(cfg_busy_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .proc_tdata_o(proc_tdata_o), .proc_tvalid_o(proc_tvalid_o), .proc_tready_i(proc_tready_i)
);

// File: tb/tdm_slot_channel_test.sv
module tdm_slot_channel_test;
  import tdm_slot_pkg::*;

  localparam int SLOTS = 32;
  localparam int SW    = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [1:0] mode = CH_BYPASS;
  logic [SW-1:0] in_slot = '0, out_slot = '0;
  logic hw_mode = 1'b0, cfg_busy = 1'b0;
  logic [7:0] proc_tdata;
  logic proc_tvalid;
  logic stall = 1'b0;
  logic [7:0] res_tdata = '0;
  logic res_tvalid = 1'b0;
  logic res_tready;
  logic running = 1'b0;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tdm_slot_channel #(.SLOTS(SLOTS), .SAMPLE_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mode_i(mode), .in_slot_i(in_slot),
    .out_slot_i(out_slot), .hw_mode_i(hw_mode), .cfg_busy_i(cfg_busy),
    .proc_tdata_o(proc_tdata), .proc_tvalid_o(proc_tvalid), .proc_tready_i(!stall),
    .res_tdata_i(res_tdata), .res_tvalid_i(res_tvalid), .res_tready_o(res_tready)
  );

  function automatic logic [7:0] xf(input logic [7:0] x);
    return {x[3:0], x[7:4]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] pat(input int fr, input int s);
    return 8'((fr * 37 + s * 13 + 5) & 255);
  endfunction

  // Processing engine peer: one-cycle answer to each accepted sample.
  always @(posedge clk) begin
    res_tvalid <= 1'b0;
    if (proc_tvalid && !stall) begin
      res_tvalid <= 1'b1;
      res_tdata  <= xf(proc_tdata);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Behavioural reference model
  int m_bit = 7, m_slot = SLOTS - 1;
  logic [7:0] m_rx = '0, m_buf = '0, m_tx = '0, last_cap = '0;
  logic m_oe = 1'b0, m_sdo = 1'b0;

  function automatic int rx_eff();  return hw_mode ? 0 : int'(in_slot);  endfunction
  function automatic int tx_eff();  return hw_mode ? 0 : int'(out_slot); endfunction

  task automatic model_rise(input logic fs, input logic d);
    if (fs) begin m_bit = 0; m_slot = 0; end
    else if (m_bit == 7) begin m_bit = 0; m_slot = (m_slot == SLOTS - 1) ? 0 : m_slot + 1; end
    else m_bit++;
    if (m_slot == rx_eff()) begin
      m_rx = {m_rx[6:0], d};
      if (m_bit == 7) begin
        if (mode == CH_BYPASS) m_buf = m_rx;
        else if (mode == CH_ACTIVE || mode == CH_MUTE) begin
          last_cap = m_rx;
          if (!stall) m_buf = xf(m_rx);
        end
      end
    end
  endtask

  task automatic model_fall();
    if (m_slot == tx_eff()) begin
      m_oe = 1'b1;
      if (m_bit == 0) m_tx = m_buf;
      m_sdo = m_tx[7 - m_bit];
    end else m_oe = 1'b0;
  endtask

  task automatic do_bit(input logic fs, input logic d);
    logic exp_oe;
    if (bclk) model_fall();
    bclk = 1'b0; fsync = fs; sdi = d;
    repeat (7) @(posedge clk);
    #1;
    exp_oe = m_oe && (mode == CH_ACTIVE || mode == CH_BYPASS) && !cfg_busy;
    check(cur_req, {31'd0, sdo_oe}, {31'd0, exp_oe});
    if (exp_oe) check(cur_req, {31'd0, sdo}, {31'd0, m_sdo});
    if (mode == CH_IDLE) check("R7", {31'd0, proc_tvalid}, 32'd0);
    @(posedge clk);
    bclk = 1'b1;
    model_rise(fs, d);
    repeat (8) @(posedge clk);
  endtask

  task automatic run_frame(input int fr, input bit with_fs, input int nslots);
    for (int s = 0; s < nslots; s++) begin
      for (int b = 0; b < 8; b++) begin
        logic [7:0] w;
        w = pat(fr, s);
        do_bit(with_fs && s == 0 && b == 0, w[7 - b]);
      end
    end
  endtask

  // Every-clock comparison of the gating rules
  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (sdo_oe && (cfg_busy || mode == CH_IDLE || mode == CH_MUTE)) begin
        fails++;
        $display("FAIL R9/R8: actual oe 1 expected 0");
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", {31'd0, sdo_oe}, 32'd0);
    check("R1", {31'd0, proc_tvalid}, 32'd0);
    check("R1", {31'd0, res_tready}, 32'd1);
    running = 1'b1;

    // R11 then R3: transmit slot before receive slot in bypass
    mode = CH_BYPASS; in_slot = 5; out_slot = 3;
    cur_req = "R11"; run_frame(0, 1, SLOTS);
    cur_req = "R3";  run_frame(1, 1, SLOTS);
    // R6: same slot for both directions
    in_slot = 7; out_slot = 7;
    cur_req = "R6"; run_frame(2, 1, SLOTS);
    // R4/R5: active processing, answer sent next frame
    mode = CH_ACTIVE; in_slot = 10; out_slot = 2;
    cur_req = "R5"; run_frame(3, 1, SLOTS);
    cur_req = "R4"; run_frame(4, 1, SLOTS);
    // R8: mute keeps processing; next active frame shows its answer
    mode = CH_MUTE; cur_req = "R8"; run_frame(5, 1, SLOTS);
    mode = CH_ACTIVE; run_frame(6, 1, SLOTS);
    // R7: idle leaves the transmit word untouched
    mode = CH_IDLE; cur_req = "R7"; run_frame(7, 1, SLOTS);
    mode = CH_BYPASS; in_slot = 20; out_slot = 1; run_frame(8, 1, SLOTS);
    // R10: strap forces slot 0
    hw_mode = 1'b1; in_slot = 7; out_slot = 20;
    cur_req = "R10"; run_frame(9, 1, SLOTS); run_frame(10, 1, SLOTS);
    hw_mode = 1'b0; in_slot = 6; out_slot = 12;
    // R9: configuration busy
    cfg_busy = 1'b1; cur_req = "R9"; run_frame(11, 1, SLOTS);
    cfg_busy = 1'b0; run_frame(12, 1, SLOTS);
    // R2: wrap without frame sync, partial frame, then resync
    cur_req = "R2"; run_frame(13, 0, SLOTS);
    run_frame(14, 1, 10);
    run_frame(15, 1, SLOTS);
    // R4: back-pressure, newest sample wins
    mode = CH_ACTIVE; in_slot = 4; out_slot = 1; stall = 1'b1;
    cur_req = "R4"; run_frame(16, 1, SLOTS); run_frame(17, 1, SLOTS);
    #1;
    check("R4", {31'd0, proc_tvalid}, 32'd1);
    check("R4", {24'd0, proc_tdata}, {24'd0, pat(17, 4)});
    stall = 1'b0;
    m_buf = xf(last_cap);
    repeat (4) @(posedge clk);
    run_frame(18, 1, SLOTS);

    running = 1'b0;
    finish_run();
  end

endmodule